// File: doc/BRIEF.md
# Divider-Free Modular Residue Generator

This block forms the remainder of an 8-bit unsigned word for one of three small check moduli: 3, 7 or 9. A two-bit selector picks the modulus. The block uses no divider. The word is cut into narrow digit groups, and the groups are combined with modular additions.

- For 3 and 7, which have the form 2^k−1, the groups are k bits wide. They are summed by a chain of k-bit adders whose carry-out wraps back in as carry-in.
- For 9, which has the form 2^k+1, the groups are 3 bits wide and enter with alternating signs.

The result is always the canonical residue, zero-extended to a 4-bit output.

The block is purely combinational. A residue checker beside an arithmetic unit would use it, for example to compress converter output codes or operands into short check values. The residue follows any change of the input word or selector with no clock edge in between.

Top module: `modres_gen`

## Requirements
- R1: With `mode_sel` = 0 the output equals `data_in` mod 3, held in bits 1:0, and bits 3:2 are zero. Words 0 to 15 therefore give 0, 1, 2, 0, 1, 2, and so on.
- R2: With `mode_sel` = 1 the output equals `data_in` mod 7. Internally the bits with weights congruent to 1, 2 and 4 form the three columns of a 3-bit wrap-around sum.
- R3: With `mode_sel` = 2 the output equals `data_in` mod 9 and always lies in 0..8.
- R4: With `mode_sel` = 3 the output is 0 for every input word.
- R5: Any word that is a multiple of 7, for example 7, 63 or 252, gives 0 in mode 1 and never 7. Any multiple of 3 gives 0 in mode 0 and never 3.
- R6: In mode 2, words whose alternating 3-bit group sum is negative still give the correct non-negative residue. For example 56 (groups 0, 7, 0) gives 2, and 40 gives 4.
- R7: The output settles to the new residue within the same clock period as an input change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 8 | Unsigned word whose residue is formed |
| mode_sel | input | 2 | Modulus select: 0 = mod 3, 1 = mod 7, 2 = mod 9, 3 = disabled (zero) |
| residue_out | output | 4 | Canonical residue, zero-extended |

## Verification
Every one of the 256 words is applied under each of the four selector codes. This separates a wrong column split or lost wrap-around carry, which misplaces whole residue classes, from a missing final normalisation, which only fails on the multiples of the modulus.

Directed words whose groups cancel to a multiple of 7, or whose alternating sum goes negative for 9, isolate the all-ones fold and the sign bias. Seeded random words and selector switches, sampled without an intervening clock edge, show that the output is combinational and has no stale state.

// File: rtl/modres_pkg.sv
package modres_pkg;

    typedef enum logic [1:0] {
        MODE_MOD3 = 2'd0,
        MODE_MOD7 = 2'd1,
        MODE_MOD9 = 2'd2,
        MODE_OFF  = 2'd3
    } modsel_e;

    localparam int GROUP_W_MOD9 = 3;
    localparam int MOD9_VALUE   = 9;

endpackage

// File: rtl/modres_eac_add.sv
// k-bit adder whose carry-out is folded back in as carry-in (mod 2^k-1 sum).
module modres_eac_add #(
    parameter int K = 3
) (
    input  logic [K-1:0] a_in,
    input  logic [K-1:0] b_in,
    output logic [K-1:0] sum_out
);
    localparam int M = (1 << K) - 1;

    logic [K:0] raw_sum;

    always_comb begin
        raw_sum = {1'b0, a_in} + {1'b0, b_in};
        // low part is at most 2^K-2 when carry is set, so this never overflows
        sum_out = raw_sum[K-1:0] + {{(K-1){1'b0}}, raw_sum[K]};
    end

    // R2: wrapped sum stays congruent to the plain sum modulo 2^K-1
    always_comb begin
        a_r2_eac_congruent: assert ((32'(a_in) + 32'(b_in)) % M == 32'(sum_out) % M)
            else $error("wrap-around adder lost congruence");
    end

endmodule

// File: rtl/modres_mersenne_fold.sv
// Residue modulo 2^K-1: K-bit groups summed by a chain of wrap-around adders.
module modres_mersenne_fold #(
    parameter int W = 8,
    parameter int K = 3
) (
    input  logic [W-1:0] word_in,
    output logic [K-1:0] res_out
);
    localparam int NG = (W + K - 1) / K;
    localparam int PW = NG * K;
    localparam int M  = (1 << K) - 1;

    logic [PW-1:0] padded;
    logic [K-1:0]  partial [NG];

    assign padded     = PW'(word_in);
    assign partial[0] = padded[K-1:0];

    generate
        for (genvar gi = 1; gi < NG; gi++) begin : g_chain
            modres_eac_add #(.K(K)) u_add (
                .a_in   (partial[gi-1]),
                .b_in   (padded[gi*K +: K]),
                .sum_out(partial[gi])
            );
        end
    endgenerate

    // all-ones is the second code for zero in ones'-complement style sums
    assign res_out = (partial[NG-1] == {K{1'b1}}) ? '0 : partial[NG-1];

    // R5: output is canonical and equals the true remainder
    always_comb begin
        a_r5_canonical: assert (res_out != {K{1'b1}})
            else $error("non-canonical all-ones residue");
        a_r2_fold_value: assert (32'(res_out) == 32'(word_in) % M)
            else $error("fold residue mismatch");
    end

endmodule

// File: rtl/modres_alt_fold.sv
// Residue modulo 9: 3-bit groups with weights +1,-1,+1,...; subtracted
// groups are inverted (7-g) and a constant bias restores the offset.
module modres_alt_fold
    import modres_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] word_in,
    output logic [3:0]   res_out
);
    localparam int K       = GROUP_W_MOD9;
    localparam int NG      = (W + K - 1) / K;
    localparam int PW      = NG * K;
    localparam int NNEG    = NG / 2;
    localparam int BIAS    = (2 * NNEG) % MOD9_VALUE;
    localparam int ACC_MAX = NG * 7 + BIAS;
    localparam int ACC_W   = $clog2(ACC_MAX + 1) + 1;
    localparam int MAXSUB  = ACC_MAX / MOD9_VALUE;

    logic [PW-1:0]    padded;
    logic [K-1:0]     term [NG];
    logic [ACC_W-1:0] acc;

    assign padded = PW'(word_in);

    generate
        for (genvar gi = 0; gi < NG; gi++) begin : g_term
            if ((gi % 2) == 0) begin : g_pos
                assign term[gi] = padded[gi*K +: K];
            end else begin : g_neg
                assign term[gi] = ~padded[gi*K +: K];
            end
        end
    endgenerate

    always_comb begin
        acc = ACC_W'(BIAS);
        for (int i = 0; i < NG; i++) begin
            acc = acc + ACC_W'(term[i]);
        end
        for (int s = 0; s < MAXSUB; s++) begin
            if (acc >= ACC_W'(MOD9_VALUE)) begin
                acc = acc - ACC_W'(MOD9_VALUE);
            end
        end
        res_out = acc[3:0];
    end

    // R6: result matches the signed alternating group sum, wrapped into 0..8
    always_comb begin
        int signed alt;
        alt = 0;
        for (int i = 0; i < NG; i++) begin
            if ((i % 2) == 0) alt = alt + int'(padded[i*K +: K]);
            else              alt = alt - int'(padded[i*K +: K]);
        end
        a_r6_alt_sign: assert (int'(res_out) == (((alt % 9) + 9) % 9))
            else $error("alternating-sign residue mismatch");
        a_r3_range: assert (res_out < 4'd9)
            else $error("mod-9 residue out of range");
    end

endmodule

// File: rtl/modres_gen.sv
module modres_gen
    import modres_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RES_W  = 4
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        mode_sel,
    output logic [RES_W-1:0]  residue_out
);
    localparam int K3 = 2;
    localparam int K7 = 3;

    logic [K3-1:0] res_m3;
    logic [K7-1:0] res_m7;
    logic [3:0]    res_m9;

    modres_mersenne_fold #(.W(DATA_W), .K(K3)) u_fold3 (
        .word_in(data_in),
        .res_out(res_m3)
    );

    modres_mersenne_fold #(.W(DATA_W), .K(K7)) u_fold7 (
        .word_in(data_in),
        .res_out(res_m7)
    );

    modres_alt_fold #(.W(DATA_W)) u_fold9 (
        .word_in(data_in),
        .res_out(res_m9)
    );

    always_comb begin
        unique case (mode_sel)
            MODE_MOD3: residue_out = RES_W'(res_m3);
            MODE_MOD7: residue_out = RES_W'(res_m7);
            MODE_MOD9: residue_out = RES_W'(res_m9);
            MODE_OFF:  residue_out = '0;
        endcase
    end

    // R1 / R4: output width use per mode
    always_comb begin
        if (mode_sel == MODE_MOD3) begin
            a_r1_upper_zero: assert (residue_out[RES_W-1:2] == '0)
                else $error("mod-3 residue uses upper bits");
        end
        if (mode_sel == MODE_OFF) begin
            a_r4_off_zero: assert (residue_out == '0)
                else $error("disabled mode output not zero");
        end
    end

endmodule

// File: tb/modres_gen_test.sv
`timescale 1ns/1ps
module modres_gen_test;

    logic       clk = 1'b0;
    logic [7:0] data_in = 8'd0;
    logic [1:0] mode_sel = 2'd0;
    logic [3:0] residue_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    modres_gen uut (
        .data_in    (data_in),
        .mode_sel   (mode_sel),
        .residue_out(residue_out)
    );

    function automatic logic [3:0] expect_res(input logic [7:0] v, input logic [1:0] m);
        case (m)
            2'd0:    return 4'(int'(v) % 3);
            2'd1:    return 4'(int'(v) % 7);
            2'd2:    return 4'(int'(v) % 9);
            default: return 4'd0;
        endcase
    endfunction

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp_v,
                         input logic [7:0] v, input logic [1:0] m);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s data=%0d mode=%0d actual=%0d expected=%0d", req, v, m, act, exp_v);
        end
    endtask

    task automatic apply_check(input string req, input logic [7:0] v, input logic [1:0] m);
        @(negedge clk);
        data_in  = v;
        mode_sel = m;
        #5;
        check(req, residue_out, expect_res(v, m), v, m);
    endtask

    initial begin
        // reset-state check: all-zero word gives zero residue
        #5;
        check("R1", residue_out, 4'd0, 8'd0, 2'd0);

        // exhaustive sweep: R1 R2 R3 R4
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 256; v++) begin
                apply_check(mode_req(2'(m)), 8'(v), 2'(m));
            end
        end

        // R5: multiples fold to zero, never the all-ones code
        apply_check("R5", 8'd7,   2'd1);
        apply_check("R5", 8'd63,  2'd1);
        apply_check("R5", 8'd252, 2'd1);
        apply_check("R5", 8'd255, 2'd0);
        apply_check("R5", 8'd3,   2'd0);

        // R6: negative alternating sums for mod 9
        apply_check("R6", 8'd56,  2'd2);
        apply_check("R6", 8'd40,  2'd2);
        apply_check("R6", 8'd63,  2'd2);
        apply_check("R6", 8'd255, 2'd2);

        // R7: output follows input changes without a clock edge
        @(negedge clk);
        data_in = 8'd200; mode_sel = 2'd1;
        #1; check("R7", residue_out, expect_res(8'd200, 2'd1), 8'd200, 2'd1);
        data_in = 8'd201;
        #1; check("R7", residue_out, expect_res(8'd201, 2'd1), 8'd201, 2'd1);
        mode_sel = 2'd2;
        #1; check("R7", residue_out, expect_res(8'd201, 2'd2), 8'd201, 2'd2);
        mode_sel = 2'd3;
        #1; check("R7", residue_out, 4'd0, 8'd201, 2'd3);

        // seeded random mix
        void'($urandom(32'd20250101));
        for (int i = 0; i < 400; i++) begin
            logic [7:0] rv;
            logic [1:0] rm;
            rv = 8'($urandom);
            rm = 2'($urandom);
            apply_check(mode_req(rm), rv, rm);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule